// File: doc/BRIEF.md
# Time-Coded Cellular Neural Network Grid

This block is a rectangular grid of image cells that step together. Each cell holds one pixel as a 5-bit sign-magnitude value, with a sign bit and a magnitude from 0 to 15. The grid has the usual 3×3 coupling: a cell takes the values of its eight surrounding cells and its own value. It weights each of these nine inputs with a shared signed template and sums the results. The sum goes through a saturating transfer function, and the result becomes the cell's new value.

The cells contain no multipliers. A shared slot counter splits every iteration into 15 clock cycles. During those cycles each input magnitude becomes a pulse whose length equals the magnitude. Each weight magnitude becomes a spread-out pattern of slots, generated once for the whole grid. In each slot a cell ANDs the pulse with the weight pattern and XORs the two signs. An up/down count of the coincidences gives the rounded product.

The block is used as follows. A caller presents the image, the template and an iteration count, then pulses `start`. The grid runs the requested number of iterations and pulses `done`. The caller then reads every cell's register from `image_out`.

The controller has three states:
- `ST_IDLE`: waits for `start`. The transition IDLE→RUN is taken on `start` when the count is non-zero. The transition IDLE→FINISH is taken on `start` when the count is zero.
- `ST_RUN`: steps the slot counter. The transition RUN→FINISH is taken in slot 14 of the last iteration.
- `ST_FINISH`: raises `done`. It always returns to IDLE (FINISH→IDLE).

Top module: `cnn_array`

## Requirements
- R1: After reset, `busy` and `done` are 0 and every cell in `image_out` reads 0.
- R2: `start` sampled high in `ST_IDLE` loads every cell from `image_in` at that clock edge. A loaded value with magnitude 0 is stored as +0 (code 5'b00000). With a count of 0, `done` follows on the next cycle and the image is unchanged.
- R3: Each iteration takes 15 clocks. Counting the `start` edge as edge 0, the last update and the rise of `done` both happen at edge 15·N. `done` stays high for exactly one cycle.
- R4: An input of magnitude m under a weight of magnitude w contributes round(m·w/15) = floor((2·m·w+15)/30) to the net sum. The contribution is negative when the sign bits differ. Example: 8 under 9 contributes 5.
- R5: The new value is the net sum clamped to the range −15..+15. Its sign is bit 4 and its magnitude is bits 3:0. A zero result is always +0.
- R6: Template tap k sits at bits [5k+4:5k]. It weights the neighbour at row offset k/3−1 and column offset k%3−1, so tap 4 is the cell itself. Cell (r,c) occupies bits [5(r·COLS+c)+4 : 5(r·COLS+c)] of both image buses.
- R7: Neighbour positions outside the grid contribute zero.
- R8: The template and the count are sampled at the `start` edge. Changes to `weights`, `image_in`, `iters` or `start` during a run have no effect on the result.
- R9: `image_out` changes only at the end of an iteration, in slot 14.
- R10: `busy` is high from the `start` edge until the last update and is low while `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Load-and-run request, accepted only in idle |
| iters | input | ITER_W | Number of iterations to run |
| weights | input | 45 | Nine signed 5-bit template taps |
| image_in | input | ROWS·COLS·5 | Initial pixel values |
| busy | output | 1 | Iterations in progress |
| done | output | 1 | One-cycle completion pulse |
| image_out | output | ROWS·COLS·5 | Registered cell values |

## Verification
The assertions assume that `start` is low or ignored outside `ST_IDLE`. They also assume that `rst_n` is held low for at least one edge before any stimulus. The stem of the argument is that the template register is written only on an accepted start. That is why the stability checks on the template and the image hold regardless of how `weights` and `image_in` move during a run.

The stimulus keeps within these assumptions. It raises `start` for exactly one cycle in idle. The one exception is a deliberate second pulse in mid-run, which the design must ignore. Pixel and weight values are drawn from the full sign-magnitude range, including negative zero.

// File: rtl/cnn_pkg.sv
package cnn_pkg;
    localparam int PIX_W   = 5;
    localparam int MAG_W   = 4;
    localparam int MAG_MAX = 15;
    localparam int TAPS    = 9;
    localparam int SLOTS   = 15;
    localparam int SLOT_W  = $clog2(SLOTS);

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RUN    = 2'd1,
        ST_FINISH = 2'd2
    } ctrl_state_e;
endpackage

// File: rtl/cnn_ctrl.sv
module cnn_ctrl
    import cnn_pkg::*;
#(
    parameter int ITER_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ITER_W-1:0] iters,
    output logic              load,
    output logic              step,
    output logic              last,
    output logic [SLOT_W-1:0] slot,
    output logic              busy,
    output logic              done
);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);

    ctrl_state_e       state, state_nx;
    logic [ITER_W-1:0] iter_left;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (start) state_nx = (iters == '0) ? ST_FINISH : ST_RUN;
            ST_RUN:    if (last && iter_left == ITER_W'(1)) state_nx = ST_FINISH;
            ST_FINISH: state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        load = 1'b0;
        step = 1'b0;
        busy = 1'b0;
        done = 1'b0;
        unique case (state)
            ST_IDLE:   load = start;
            ST_RUN:    begin step = 1'b1; busy = 1'b1; end
            ST_FINISH: done = 1'b1;
            default:   ;
        endcase
    end

    assign last = step && (slot == LAST_SLOT);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot      <= '0;
            iter_left <= '0;
        end else if (load) begin
            slot      <= '0;
            iter_left <= iters;
        end else if (step) begin
            if (last) begin
                slot      <= '0;
                iter_left <= iter_left - ITER_W'(1);
            end else begin
                slot <= slot + SLOT_W'(1);
            end
        end
    end
endmodule

// File: rtl/cnn_wgt_gate.sv
module cnn_wgt_gate
    import cnn_pkg::*;
(
    input  logic [SLOT_W-1:0]       slot,
    input  logic [TAPS*PIX_W-1:0]   w_q,
    output logic [TAPS-1:0]         wbit,
    output logic [TAPS-1:0]         wsgn
);
    localparam int NUM_W = $clog2(2 * SLOTS * MAG_MAX + SLOTS + 1);
    localparam logic [NUM_W-1:0] DEN  = NUM_W'(2 * SLOTS);
    localparam logic [NUM_W-1:0] HALF = NUM_W'(SLOTS);

    for (genvar k = 0; k < TAPS; k++) begin : g_tap
        logic [NUM_W-1:0] mag, s_lo, s_hi, lo_num, hi_num;
        assign mag    = NUM_W'(w_q[k*PIX_W +: MAG_W]);
        assign s_lo   = NUM_W'(slot);
        assign s_hi   = s_lo + NUM_W'(1);
        assign lo_num = NUM_W'(2) * s_lo * mag + HALF;
        assign hi_num = NUM_W'(2) * s_hi * mag + HALF;
        assign wbit[k] = (hi_num / DEN) != (lo_num / DEN);
        assign wsgn[k] = w_q[k*PIX_W + MAG_W];
    end
endmodule

// File: rtl/cnn_cell.sv
module cnn_cell
    import cnn_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load,
    input  logic                  step,
    input  logic                  last,
    input  logic [SLOT_W-1:0]     slot,
    input  logic [PIX_W-1:0]      load_val,
    input  logic [TAPS*PIX_W-1:0] nbr,
    input  logic [TAPS-1:0]       wbit,
    input  logic [TAPS-1:0]       wsgn,
    output logic [PIX_W-1:0]      pix_q
);
    localparam int ACC_W = $clog2(TAPS * MAG_MAX + 1) + 1;
    localparam logic signed [ACC_W-1:0] ONE  = ACC_W'(1);
    localparam logic signed [ACC_W-1:0] PMAX = ACC_W'(MAG_MAX);
    localparam logic signed [ACC_W-1:0] NMAX = -PMAX;

    logic signed [ACC_W-1:0] acc, delta, acc_nx;

    function automatic logic [PIX_W-1:0] squash(input logic signed [ACC_W-1:0] v);
        logic signed [ACC_W-1:0] neg;
        neg = -v;
        if (v > PMAX)      return {1'b0, MAG_W'(MAG_MAX)};
        else if (v < NMAX) return {1'b1, MAG_W'(MAG_MAX)};
        else if (v < 0)    return {1'b1, neg[MAG_W-1:0]};
        else               return {1'b0, v[MAG_W-1:0]};
    endfunction

    always_comb begin
        delta = '0;
        for (int k = 0; k < TAPS; k++) begin
            if (wbit[k] && (nbr[k*PIX_W +: MAG_W] > MAG_W'(slot))) begin
                if (nbr[k*PIX_W + MAG_W] ^ wsgn[k]) delta = delta - ONE;
                else                                delta = delta + ONE;
            end
        end
        acc_nx = acc + delta;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc   <= '0;
            pix_q <= '0;
        end else if (load) begin
            acc   <= '0;
            pix_q <= (load_val[MAG_W-1:0] == '0) ? '0 : load_val;
        end else if (step) begin
            if (last) begin
                acc   <= '0;
                pix_q <= squash(acc_nx);
            end else begin
                acc <= acc_nx;
            end
        end
    end
endmodule

// File: rtl/cnn_array.sv
module cnn_array
    import cnn_pkg::*;
#(
    parameter int ROWS   = 4,
    parameter int COLS   = 4,
    parameter int ITER_W = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start,
    input  logic [ITER_W-1:0]           iters,
    input  logic [TAPS*PIX_W-1:0]       weights,
    input  logic [ROWS*COLS*PIX_W-1:0]  image_in,
    output logic                        busy,
    output logic                        done,
    output logic [ROWS*COLS*PIX_W-1:0]  image_out
);
    localparam int CELLS = ROWS * COLS;

    logic                  load, step, last;
    logic [SLOT_W-1:0]     slot;
    logic [TAPS*PIX_W-1:0] w_q;
    logic [TAPS-1:0]       wbit, wsgn;
    logic [PIX_W-1:0]      cell_q [CELLS];

    cnn_ctrl #(.ITER_W(ITER_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .iters(iters),
        .load(load), .step(step), .last(last), .slot(slot),
        .busy(busy), .done(done)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)    w_q <= '0;
        else if (load) w_q <= weights;
    end

    cnn_wgt_gate u_wgt (.slot(slot), .w_q(w_q), .wbit(wbit), .wsgn(wsgn));

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        for (genvar c = 0; c < COLS; c++) begin : g_col
            localparam int IDX = r * COLS + c;
            logic [TAPS*PIX_W-1:0] nbr;
            for (genvar k = 0; k < TAPS; k++) begin : g_tap
                localparam int RR = r + k / 3 - 1;
                localparam int CC = c + k % 3 - 1;
                if (RR >= 0 && RR < ROWS && CC >= 0 && CC < COLS) begin : g_in
                    assign nbr[k*PIX_W +: PIX_W] = cell_q[RR*COLS + CC];
                end else begin : g_edge
                    assign nbr[k*PIX_W +: PIX_W] = '0;
                end
            end
            cnn_cell u_cell (
                .clk(clk), .rst_n(rst_n), .load(load), .step(step), .last(last),
                .slot(slot), .load_val(image_in[IDX*PIX_W +: PIX_W]), .nbr(nbr),
                .wbit(wbit), .wsgn(wsgn), .pix_q(cell_q[IDX])
            );
            assign image_out[IDX*PIX_W +: PIX_W] = cell_q[IDX];
        end
    end
endmodule

// File: rtl/cnn_array_chk.sv
module cnn_array_chk #(
    parameter int CELLS  = 16,
    parameter int PIX_W  = 5,
    parameter int SLOT_W = 4,
    parameter int W_BITS = 45
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    start,
    input logic                    busy,
    input logic                    done,
    input logic [SLOT_W-1:0]       slot,
    input logic [W_BITS-1:0]       w_q,
    input logic [CELLS*PIX_W-1:0]  image_out
);
    localparam logic [SLOT_W-1:0] END_SLOT = SLOT_W'(14);

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R3
    AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (!rst_n) busy |-> slot <= END_SLOT); // R3
    AST_DONE_IDLE_RUN: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy); // R10
    AST_RUN_FROM_START: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> $past(start)); // R10
    AST_TEMPLATE_HELD: assert property (@(posedge clk) disable iff (!rst_n) busy |=> $stable(w_q)); // R8
    AST_IMAGE_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && slot != END_SLOT) |=> $stable(image_out)); // R9

    always_ff @(posedge clk) begin
        if (rst_n) begin
            for (int i = 0; i < CELLS; i++) begin
                AST_NO_NEG_ZERO: assert (!(image_out[i*PIX_W + PIX_W - 1] &&
                                  image_out[i*PIX_W +: PIX_W-1] == '0)); // R5
            end
        end
    end
endmodule

bind cnn_array cnn_array_chk #(
    .CELLS(ROWS*COLS), .PIX_W(cnn_pkg::PIX_W),
    .SLOT_W(cnn_pkg::SLOT_W), .W_BITS(cnn_pkg::TAPS*cnn_pkg::PIX_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .slot(slot), .w_q(w_q), .image_out(image_out)
);

// File: tb/test_cnn_array.sv
module test_cnn_array;
    localparam int ROWS = 4, COLS = 4, CELLS = ROWS * COLS, ITER_W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [ITER_W-1:0] iters = '0;
    logic [44:0] weights = '0;
    logic [CELLS*5-1:0] image_in = '0;
    logic busy, done;
    logic [CELLS*5-1:0] image_out;

    always #4 clk = ~clk;

    cnn_array #(.ROWS(ROWS), .COLS(COLS), .ITER_W(ITER_W)) i_cnn_array (
        .clk(clk), .rst_n(rst_n), .start(start), .iters(iters), .weights(weights),
        .image_in(image_in), .busy(busy), .done(done), .image_out(image_out)
    );

    int checks = 0, fails = 0;
    int cur [CELLS];
    int tmpl [9];
    logic [4:0] codes [CELLS];

    function automatic logic [4:0] enc(int v);
        return (v < 0) ? {1'b1, 4'(-v)} : {1'b0, 4'(v)};
    endfunction

    function automatic int dec(logic [4:0] p);
        return p[4] ? -int'(p[3:0]) : int'(p[3:0]);
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic model_iter();
        int nxt [CELLS];
        for (int r = 0; r < ROWS; r++) begin
            for (int c = 0; c < COLS; c++) begin
                int net = 0;
                for (int k = 0; k < 9; k++) begin
                    int rr = r + k / 3 - 1;
                    int cc = c + k % 3 - 1;
                    int v = 0;
                    int m, wm, p;
                    if (rr >= 0 && rr < ROWS && cc >= 0 && cc < COLS) v = cur[rr*COLS + cc];
                    m  = (v < 0) ? -v : v;
                    wm = (tmpl[k] < 0) ? -tmpl[k] : tmpl[k];
                    p  = (2 * m * wm + 15) / 30;
                    net += ((v < 0) != (tmpl[k] < 0)) ? -p : p;
                end
                if (net > 15) net = 15;
                if (net < -15) net = -15;
                nxt[r*COLS + c] = net;
            end
        end
        for (int i = 0; i < CELLS; i++) cur[i] = nxt[i];
    endtask

    // Loads codes/tmpl, runs n iterations, checks timing and result.
    task automatic run_case(int n, bit disturb, string req);
        int c;
        bit busy_ok, stable_ok;
        logic [CELLS*5-1:0] prev;
        for (int i = 0; i < CELLS; i++) begin
            image_in[i*5 +: 5] = codes[i];
            cur[i] = dec(codes[i]);
        end
        for (int k = 0; k < 9; k++) weights[k*5 +: 5] = enc(tmpl[k]);
        @(negedge clk);
        start = 1'b1;
        iters = ITER_W'(n);
        @(negedge clk);
        start = 1'b0;
        c = 1;
        busy_ok = 1'b1;
        stable_ok = 1'b1;
        prev = image_out;
        while (!done && c <= 15 * n + 5) begin
            if (busy !== (c <= 15 * n)) busy_ok = 1'b0;
            if (image_out !== prev && c > 1 && (c - 1) % 15 != 0) stable_ok = 1'b0;
            prev = image_out;
            if (disturb && c == 3) begin
                weights  = ~weights;
                image_in = ~image_in;
                iters    = iters + ITER_W'(3);
                start    = 1'b1;
            end
            if (disturb && c == 4) start = 1'b0;
            @(negedge clk);
            c++;
        end
        check(done === 1'b1 && c == 15 * n + 1, "R3", "done latency", c, 15 * n + 1);
        check(busy === 1'b0, "R10", "busy during done", busy, 0);
        check(busy_ok, "R10", "busy window", busy_ok, 1);
        check(stable_ok, "R9", "image changed mid-iteration", stable_ok, 1);
        for (int i = 0; i < n; i++) model_iter();
        for (int i = 0; i < CELLS; i++)
            check(image_out[i*5 +: 5] === enc(cur[i]), req, $sformatf("cell %0d", i),
                  int'(image_out[i*5 +: 5]), int'(enc(cur[i])));
        @(negedge clk);
        check(done === 1'b0, "R3", "done width", done, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int seed;
        seed = $urandom(32'd2024);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(busy === 1'b0, "R1", "busy", busy, 0);
        check(done === 1'b0, "R1", "done", done, 0);
        check(image_out === '0, "R1", "image", int'(image_out != '0), 0);

        // R2: zero iterations, negative zero normalised
        for (int i = 0; i < CELLS; i++) codes[i] = enc(i - 7);
        codes[5] = 5'b10000;
        for (int k = 0; k < 9; k++) tmpl[k] = 3;
        run_case(0, 1'b0, "R2");

        // R4: single product 8 x 9 -> 5, and its negative
        for (int i = 0; i < CELLS; i++) codes[i] = '0;
        for (int k = 0; k < 9; k++) tmpl[k] = 0;
        tmpl[4] = 9;
        codes[5] = enc(8);
        codes[10] = enc(-8);
        run_case(1, 1'b0, "R4");
        check(image_out[5*5 +: 5] === enc(5), "R4", "8*9 rounding",
              int'(image_out[5*5 +: 5]), int'(enc(5)));

        // R5: saturation both ways
        for (int i = 0; i < CELLS; i++) codes[i] = enc((i % 2) ? 15 : -15);
        for (int k = 0; k < 9; k++) tmpl[k] = 15;
        run_case(1, 1'b0, "R5");
        for (int k = 0; k < 9; k++) tmpl[k] = -15;
        for (int i = 0; i < CELLS; i++) codes[i] = enc(15);
        run_case(2, 1'b0, "R5");

        // R7: border cells see fewer neighbours (corner 4, edge 6, inner 9)
        for (int i = 0; i < CELLS; i++) codes[i] = enc(15);
        for (int k = 0; k < 9; k++) tmpl[k] = 1;
        run_case(1, 1'b0, "R7");
        check(image_out[0 +: 5] === enc(4), "R7", "corner", int'(image_out[0 +: 5]), int'(enc(4)));
        check(image_out[5 +: 5] === enc(6), "R7", "edge", int'(image_out[5 +: 5]), int'(enc(6)));

        // R6: single lit pixel with tap k weighted k
        for (int i = 0; i < CELLS; i++) codes[i] = '0;
        codes[1*COLS + 1] = enc(15);
        for (int k = 0; k < 9; k++) tmpl[k] = k;
        run_case(1, 1'b0, "R6");
        check(image_out[(0*COLS + 0)*5 +: 5] === enc(8), "R6", "tap 8 at upper-left",
              int'(image_out[0 +: 5]), int'(enc(8)));
        check(image_out[(2*COLS + 2)*5 +: 5] === enc(0), "R6", "tap 0 at lower-right",
              int'(image_out[(2*COLS + 2)*5 +: 5]), 0);

        // R8: inputs disturbed and start re-pulsed mid-run
        for (int i = 0; i < CELLS; i++) codes[i] = enc(int'($urandom_range(30)) - 15);
        for (int k = 0; k < 9; k++) tmpl[k] = int'($urandom_range(30)) - 15;
        run_case(2, 1'b1, "R8");

        // random runs
        for (int t = 0; t < 20; t++) begin
            for (int i = 0; i < CELLS; i++) codes[i] = 5'($urandom_range(31));
            for (int k = 0; k < 9; k++) tmpl[k] = int'($urandom_range(30)) - 15;
            run_case(int'($urandom_range(4, 1)), 1'b0, "R4");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule